// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Sequencer

This block takes over the row strobe, the four byte-lane column strobes and the write enable of a page-mode DRAM array whenever the array is being brought up or refreshed. After reset it counts out a power-up pause. It then runs a fixed number of warm-up refresh cycles on its own, without asking for the bus. Only after that does it raise `ready`, which tells the access controller that normal traffic may start.

Once ready, an interval timer produces one refresh demand per interval. The interval is chosen a margin below the worst-case average spacing that still covers every row within the retention period. Each demand adds to a small saturating backlog. While the backlog is non-zero the sequencer raises `bus_req` and waits for `bus_gnt`. It then runs one column-before-row refresh cycle: all column strobes fall together, the row strobe falls a set number of cycles later, both rise together, and a precharge follows. Write enable stays high throughout. The devices keep their own row counter, so no address is driven. `rfsh_done` pulses in the last precharge cycle. After it, `bus_req` is released, or held if more demands are queued.

The state machine has six states. PWRUP is the pause after reset. IDLE is the ready state with no refresh owed. REQ means the bus has been requested. CSU is column strobes low with the row strobe still high. RAS is both strobes low. PRE is the precharge, with every strobe high. The transitions are:
- PWRUP to CSU when the pause ends.
- IDLE to REQ when the backlog is non-zero.
- REQ to CSU on grant, which also takes one demand off the backlog.
- CSU to RAS, and RAS to PRE, when the current phase expires.
- PRE to CSU while warm-up cycles remain.
- PRE to IDLE after the last warm-up cycle, when `ready` is set.
- Once ready, PRE to REQ if the backlog is still non-zero, otherwise PRE to IDLE.

Top module: `dram_rfsh_seq`

## Requirements
- R1: While reset is asserted, `ras_n`, every `cas_n` bit and `we_n` are high, and `ready`, `bus_req` and `rfsh_done` are low.
- R2: No strobe moves during the power-up pause. The first column strobe fall happens on clock edge PWRUP_CYC after reset release.
- R3: Exactly WARMUP_CNT refresh cycles run before `ready`, all with `bus_req` low. `ready` rises on edge PWRUP_CYC + WARMUP_CNT*(T_CSU+T_RAS+T_PRE) and then stays high.
- R4: All `cas_n` bits always carry the same value. They fall together exactly T_CSU cycles before `ras_n` falls.
- R5: `ras_n` stays low for exactly T_RAS cycles. The column strobes stay low across that time and rise on the same edge as `ras_n`.
- R6: After `ras_n` rises, all strobes stay high for at least T_PRE cycles before the column strobes fall again.
- R7: `we_n` is high in every cycle.
- R8: Once ready, with no backlog and a prompt grant, `bus_req` rises INT_CYC+1 cycles after `ready`, and then every INT_CYC cycles.
- R9: No strobe moves after ready without a grant. The column strobes fall on the edge after `bus_gnt` is first seen high in REQ. `bus_req` stays high until `rfsh_done`. `rfsh_done` is a one-cycle pulse in the last precharge cycle, which comes T_CSU+T_RAS+T_PRE-1 cycles after the column strobes fall. With no backlog, `bus_req` is low in the next cycle.
- R10: Refresh demands that arrive while the grant is withheld are kept up to PEND_MAX. When the grant comes, exactly that many refresh cycles run back to back, and the excess demands are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_gnt | input | 1 | Grant from the access controller, held while `bus_req` is high |
| bus_req | output | 1 | Request for the strobe pins, held until `rfsh_done` |
| rfsh_done | output | 1 | One-cycle pulse in the last precharge cycle of a granted refresh |
| ready | output | 1 | Pause and warm-up complete; normal access allowed |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | NUM_CAS | Column strobes, one per byte lane, active low |
| we_n | output | 1 | Write enable, active low; always high from this block |

## Verification
The assertions assume the access controller keeps `bus_gnt` high from the cycle it grants until `bus_req` drops. They also assume it never grants while `bus_req` is low, and that every phase parameter is at least one cycle. The bench's grant model follows these rules. It raises the grant only after seeing `bus_req`, after a latency swept from zero to five cycles. It holds the grant until the request falls, and it drops the grant at once when the request falls. To starve the sequencer it simply withholds the grant for several refresh intervals. It never pulls a grant away early.

// File: rtl/dram_rfsh_pkg.sv
package dram_rfsh_pkg;

    typedef enum logic [2:0] {
        ST_PWRUP = 3'd0,
        ST_IDLE  = 3'd1,
        ST_REQ   = 3'd2,
        ST_CSU   = 3'd3,
        ST_RAS   = 3'd4,
        ST_PRE   = 3'd5
    } rfsh_state_e;

endpackage

// File: rtl/rfsh_interval.sv
module rfsh_interval #(
    parameter int INT_CYC = 3000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int TW = (INT_CYC > 1) ? $clog2(INT_CYC) : 1;

    logic [TW-1:0] cnt;

    assign tick = run && (cnt == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= TW'(INT_CYC - 1);
        end else if (!run || cnt == '0) begin
            cnt <= TW'(INT_CYC - 1);
        end else begin
            cnt <= cnt - 1'b1;
        end
    end

    // Demands are spaced by the whole interval.
    AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick); // R8

endmodule

// File: rtl/rfsh_pending.sv
module rfsh_pending #(
    parameter int PEND_MAX = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic take,
    output logic pend_nz
);
    localparam int PW = $clog2(PEND_MAX + 1);

    logic [PW-1:0] cnt;

    assign pend_nz = (cnt != '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (tick && !take && cnt != PW'(PEND_MAX)) begin
            cnt <= cnt + 1'b1;
        end else if (take && !tick) begin
            cnt <= cnt - 1'b1;
        end
    end

    AST_PEND_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= PW'(PEND_MAX)); // R10
    AST_TAKE_HAS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> cnt != '0); // R10

endmodule

// File: rtl/rfsh_fsm.sv
module rfsh_fsm
    import dram_rfsh_pkg::*;
#(
    parameter int PWRUP_CYC  = 40000,
    parameter int WARMUP_CNT = 8,
    parameter int T_CSU      = 2,
    parameter int T_RAS      = 12,
    parameter int T_PRE      = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_gnt,
    input  logic pend_nz,
    output logic take,
    output logic bus_req,
    output logic rfsh_done,
    output logic ready,
    output logic ras_n,
    output logic cas_drv_n,
    output logic we_n
);
    localparam int M1   = (PWRUP_CYC > T_CSU) ? PWRUP_CYC : T_CSU;
    localparam int M2   = (T_RAS > T_PRE) ? T_RAS : T_PRE;
    localparam int MAXD = (M1 > M2) ? M1 : M2;
    localparam int CW   = $clog2(MAXD + 1);
    localparam int WW   = $clog2(WARMUP_CNT + 1);

    rfsh_state_e   state, nxt;
    logic [CW-1:0] cnt, ldv;
    logic          ld;
    logic [WW-1:0] warm;
    logic          ready_q;
    logic          warm_end;

    // Next-state and phase-load selection.
    always_comb begin
        nxt      = state;
        ld       = 1'b0;
        ldv      = '0;
        take     = 1'b0;
        warm_end = 1'b0;
        unique case (state)
            ST_PWRUP: if (cnt == '0) begin
                nxt = ST_CSU;
                ld  = 1'b1;
                ldv = CW'(T_CSU - 1);
            end
            ST_IDLE: if (pend_nz) nxt = ST_REQ;
            ST_REQ: if (bus_gnt) begin
                nxt  = ST_CSU;
                ld   = 1'b1;
                ldv  = CW'(T_CSU - 1);
                take = 1'b1;
            end
            ST_CSU: if (cnt == '0) begin
                nxt = ST_RAS;
                ld  = 1'b1;
                ldv = CW'(T_RAS - 1);
            end
            ST_RAS: if (cnt == '0) begin
                nxt = ST_PRE;
                ld  = 1'b1;
                ldv = CW'(T_PRE - 1);
            end
            ST_PRE: if (cnt == '0) begin
                if (!ready_q) begin
                    warm_end = 1'b1;
                    if (warm == WW'(WARMUP_CNT - 1)) begin
                        nxt = ST_IDLE;
                    end else begin
                        nxt = ST_CSU;
                        ld  = 1'b1;
                        ldv = CW'(T_CSU - 1);
                    end
                end else if (pend_nz) begin
                    nxt = ST_REQ;
                end else begin
                    nxt = ST_IDLE;
                end
            end
            default: nxt = ST_PWRUP;
        endcase
    end

    // State register, phase counter, warm-up count and ready flag.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_PWRUP;
            cnt     <= CW'(PWRUP_CYC - 1);
            warm    <= '0;
            ready_q <= 1'b0;
        end else begin
            state <= nxt;
            if (ld) begin
                cnt <= ldv;
            end else if (cnt != '0) begin
                cnt <= cnt - 1'b1;
            end
            if (warm_end) begin
                warm <= warm + 1'b1;
                if (warm == WW'(WARMUP_CNT - 1)) ready_q <= 1'b1;
            end
        end
    end

    // Outputs decoded from the state.
    always_comb begin
        ras_n     = (state != ST_RAS);
        cas_drv_n = !(state == ST_CSU || state == ST_RAS);
        we_n      = 1'b1;
        bus_req   = ready_q && (state == ST_REQ || state == ST_CSU ||
                                state == ST_RAS || state == ST_PRE);
        rfsh_done = ready_q && (state == ST_PRE) && (cnt == '0);
        ready     = ready_q;
    end

    AST_CAS_LEADS_RAS: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> $past(cas_drv_n) == 1'b0); // R4
    AST_REQ_UNTIL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !rfsh_done) |=> bus_req); // R9
    AST_WAIT_FOR_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_REQ && !bus_gnt) |=> cas_drv_n); // R9
    AST_READY_AFTER_WARMUP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> warm == WW'(WARMUP_CNT)); // R3
    AST_READY_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> ready); // R3

endmodule

// File: rtl/dram_rfsh_seq.sv
module dram_rfsh_seq #(
    parameter int PWRUP_CYC  = 40000,
    parameter int WARMUP_CNT = 8,
    parameter int INT_CYC    = 3000,
    parameter int T_CSU      = 2,
    parameter int T_RAS      = 12,
    parameter int T_PRE      = 8,
    parameter int PEND_MAX   = 3,
    parameter int NUM_CAS    = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_gnt,
    output logic               bus_req,
    output logic               rfsh_done,
    output logic               ready,
    output logic               ras_n,
    output logic [NUM_CAS-1:0] cas_n,
    output logic               we_n
);
    logic tick, take, pend_nz, cas_drv_n;

    rfsh_interval #(.INT_CYC(INT_CYC)) u_int (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (ready),
        .tick  (tick)
    );

    rfsh_pending #(.PEND_MAX(PEND_MAX)) u_pend (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .take    (take),
        .pend_nz (pend_nz)
    );

    rfsh_fsm #(
        .PWRUP_CYC  (PWRUP_CYC),
        .WARMUP_CNT (WARMUP_CNT),
        .T_CSU      (T_CSU),
        .T_RAS      (T_RAS),
        .T_PRE      (T_PRE)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_gnt   (bus_gnt),
        .pend_nz   (pend_nz),
        .take      (take),
        .bus_req   (bus_req),
        .rfsh_done (rfsh_done),
        .ready     (ready),
        .ras_n     (ras_n),
        .cas_drv_n (cas_drv_n),
        .we_n      (we_n)
    );

    // One column strobe per byte lane, all driven alike.
    for (genvar i = 0; i < NUM_CAS; i++) begin : g_cas
        assign cas_n[i] = cas_drv_n;
    end

endmodule

// File: tb/sim_dram_rfsh_seq.sv
`timescale 1ns/1ps
module sim_dram_rfsh_seq;
    localparam int PWRUP = 20;
    localparam int WARM  = 8;
    localparam int INT   = 64;
    localparam int TCSU  = 2;
    localparam int TRAS  = 4;
    localparam int TPRE  = 3;
    localparam int PMAX  = 3;
    localparam int NC    = 4;
    localparam int L     = TCSU + TRAS + TPRE;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_gnt = 1'b0;
    logic          bus_req, rfsh_done, ready, ras_n, we_n;
    logic [NC-1:0] cas_n;

    int checks = 0, errors = 0, cyc = 0;
    int G = 0, wcnt = 0;
    bit blk = 1'b0, per_chk = 1'b1, finished = 1'b0;

    always #2.5 clk = ~clk;

    dram_rfsh_seq #(
        .PWRUP_CYC(PWRUP), .WARMUP_CNT(WARM), .INT_CYC(INT), .T_CSU(TCSU),
        .T_RAS(TRAS), .T_PRE(TPRE), .PEND_MAX(PMAX), .NUM_CAS(NC)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .bus_gnt(bus_gnt), .bus_req(bus_req),
        .rfsh_done(rfsh_done), .ready(ready), .ras_n(ras_n), .cas_n(cas_n),
        .we_n(we_n)
    );

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", rq, act, exp, cyc);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            #2;
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    // Grant model: answers a request after G cycles, holds until it drops.
    always @(negedge clk) begin
        #1;
        if (!bus_req) begin
            bus_gnt = 1'b0;
            wcnt    = 0;
        end else if (!blk) begin
            if (wcnt >= G) bus_gnt = 1'b1;
            else           wcnt++;
        end
    end

    // Port monitor.
    logic          p_ras = 1'b1, p_rdy = 1'b0, p_req = 1'b0, p_done = 1'b0;
    logic [NC-1:0] p_cas = '1;
    int t_cf = 0, t_rf = 0, t_rr = -1000, t_rdy = 0, t_req = 0;
    int nfall = 0, nras = 0, nwarm = 0, nreq = 0, ndone = 0, g_used = 0;
    bit lat_chk = 1'b0, dchk = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (we_n !== 1'b1) chk(1'b0, "R7 we_n high", int'(we_n), 1);
            if (cas_n !== '0 && cas_n !== '1) chk(1'b0, "R4 lanes equal", int'(cas_n), 0);
            if (p_cas == '1 && cas_n == '0) begin
                chk(cyc - t_rr >= TPRE, "R6 precharge", cyc - t_rr, TPRE);
                if (nfall == 0) chk(cyc == PWRUP, "R2 pause end", cyc, PWRUP);
                if (ready) chk(bus_gnt == 1'b1, "R9 strobe needs grant", int'(bus_gnt), 1);
                if (lat_chk) begin
                    chk(cyc == t_req + g_used + 1, "R9 grant latency", cyc, t_req + g_used + 1);
                    lat_chk = 1'b0;
                end
                t_cf = cyc;
                nfall++;
            end
            if (p_ras && !ras_n) begin
                chk(cyc - t_cf == TCSU, "R4 cas setup", cyc - t_cf, TCSU);
                chk(we_n == 1'b1, "R7 we_n at row fall", int'(we_n), 1);
                if (!ready) begin
                    nwarm++;
                    chk(bus_req == 1'b0, "R3 no request in warm-up", int'(bus_req), 0);
                end
                t_rf = cyc;
                nras++;
            end
            if (!p_ras && ras_n) begin
                chk(cyc - t_rf == TRAS, "R5 row low width", cyc - t_rf, TRAS);
                chk(cas_n == '1 && p_cas == '0, "R5 cas hold", int'(cas_n), 15);
                t_rr = cyc;
            end
            if (ready && !p_rdy) begin
                chk(cyc == PWRUP + WARM * L, "R3 ready time", cyc, PWRUP + WARM * L);
                chk(nwarm == WARM, "R3 warm-up count", nwarm, WARM);
                t_rdy = cyc;
            end
            if (p_rdy && !ready) chk(1'b0, "R3 ready dropped", 0, 1);
            if (bus_req && !p_req) begin
                if (per_chk) begin
                    if (nreq == 0) chk(cyc == t_rdy + INT + 1, "R8 first request", cyc, t_rdy + INT + 1);
                    else chk(cyc - t_req == INT, "R8 request period", cyc - t_req, INT);
                end
                t_req   = cyc;
                nreq++;
                lat_chk = per_chk;
                dchk    = per_chk;
                g_used  = G;
            end
            if (rfsh_done) begin
                if (dchk) chk(cyc == t_req + g_used + L, "R9 done time", cyc, t_req + g_used + L);
                ndone++;
            end
            if (p_done && dchk) begin
                chk(bus_req == 1'b0, "R9 request released", int'(bus_req), 0);
                dchk = 1'b0;
            end
            p_ras  = ras_n;
            p_cas  = cas_n;
            p_rdy  = ready;
            p_req  = bus_req;
            p_done = rfsh_done;
        end
    end

    initial begin
        int k, n0;
        repeat (3) @(negedge clk);
        #2;
        chk(ras_n == 1'b1 && we_n == 1'b1, "R1 reset row/write high", int'(ras_n), 1);
        chk(cas_n == '1, "R1 reset cas high", int'(cas_n), 15);
        chk(ready == 1'b0 && bus_req == 1'b0 && rfsh_done == 1'b0,
            "R1 reset flags low", int'(ready), 0);
        @(negedge clk);
        rst_n = 1'b1;
        while (!ready) tick(1);
        // Sweep grant latency over steady periodic refreshes (R8, R9).
        for (int g = 0; g < 6; g++) begin
            G = g;
            k = ndone;
            while (ndone == k) tick(1);
        end
        // Withhold the grant across several intervals (R10).
        G = 1;
        per_chk = 1'b0;
        blk = 1'b1;
        k = nreq;
        while (nreq == k) tick(1);
        n0 = nras;
        tick(5 * INT + 1);
        chk(nras == n0, "R9 no refresh without grant", nras - n0, 0);
        blk = 1'b0;
        n0 = nras;
        tick(40);
        chk(nras - n0 == PMAX, "R10 backlog served", nras - n0, PMAX);
        k = nreq;
        while (nreq == k) tick(1);
        per_chk = 1'b1;
        for (int g = 0; g < 2; g++) begin
            G = 2;
            k = ndone;
            while (ndone == k) tick(1);
        end
        tick(5);
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule